// File: doc/BRIEF.md
# Exception Entry Sequencer

This unit sits beside the fetch and translation logic of a 32-bit core. Every cycle it looks at the exception requests that are pending. It picks one winner by fixed priority and performs the whole entry step in a single clock edge. The step saves a return address and a snapshot of the machine-state word into two save registers. For a data-access fault it also builds a fault status word and captures the faulting address. It produces the new machine-state word with the control bits cleared, and it outputs the handler vector.

The cycle after an entry, a one-cycle `taken` pulse reports that the outputs are valid. No request is accepted during that pulse. A request that is still held afterwards is considered again. An external or decrementer interrupt that arrives while interrupts are disabled is not lost: it stays pending until enable is set. Instruction decode, pipeline flush and handler execution belong to other blocks.

Top module: `exc_entry_unit`

## Requirements
- R1: While reset is held, and in the first cycle after it, `taken`, `vector`, `saveAddr`, `saveState`, `msrOut`, `faultStatus` and `faultAddrReg` are all zero.
- R2: When several requests are live in the same cycle, exactly one is accepted, in this order: reset (vector 0x100), machine check (0x200), synchronous fault, external interrupt, decrementer.
- R3: External and decrementer requests are accepted only while machine-state bit 15 (interrupt enable) is 1. A request held while the bit is 0 produces no `taken`, and it is accepted once the bit becomes 1.
- R4: A data fault (`syncKind` 0) loads `faultStatus` with 0x40000000 for `syncCause` 0 (no translation) or 0x08000000 for any other cause, ORed with 0x02000000 when `faultStore` is 1. It latches `faultAddr` into `faultAddrReg`. No other exception changes either register.
- R5: An instruction fault (`syncKind` 1) saves the state word with bits 31:16 replaced by its cause: 0x40000000 for cause 0, 0x08000000 for cause 1, and 0x10000000 for cause 2 or 3 (no-execute or direct-store fetch). Data and FPU-unavailable faults save the state word with bits 31:16 cleared. All other exceptions save it unchanged.
- R6: Alignment (kind 2), program (kind 3) and FPU-unavailable (kind 4) save `nextPc - 4`. Every other exception saves `nextPc`.
- R7: A program exception saves the state word with bits 31:16 cleared, then ORs in 0x00010000 and one cause bit: 0x00100000 for cause 0 (FP enabled), 0x00080000 for 1 (illegal), 0x00040000 for 2 (privileged), 0x00020000 for 3 (trap).
- R8: A program request with cause 0 is dropped while both FP mode bits (machine-state bits 11 and 8) are 0. A lower-priority request may then win in the same cycle. Sync kinds 6 and 7 are not requests.
- R9: `msrOut` equals the input state word with bits 15, 14, 13, 11, 10, 9, 8, 5, 4, 1 cleared, and bit 0 loaded from bit 16.
- R10: `vector` holds the offset of the accepted class: data 0x300, instruction 0x400, external 0x500, alignment 0x600, program 0x700, FPU unavailable 0x800, decrementer 0x900, system call (kind 5) 0xC00.
- R11: `taken` is high for exactly one cycle per accepted request. No request is accepted in a cycle where `taken` is high, so a request held constantly is accepted every second cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rstReq | input | 1 | Reset exception request |
| mchkReq | input | 1 | Machine-check request |
| syncValid | input | 1 | A synchronous fault is presented |
| syncKind | input | 3 | Fault class: 0 data, 1 instruction, 2 alignment, 3 program, 4 FPU unavailable, 5 system call |
| syncCause | input | 2 | Subcause of the fault class |
| faultStore | input | 1 | Faulting data access was a store |
| faultAddr | input | ADDR_W | Faulting data address |
| extReq | input | 1 | External interrupt request |
| decReq | input | 1 | Decrementer interrupt request |
| nextPc | input | ADDR_W | Address of the next instruction |
| msrIn | input | 32 | Current machine-state word |
| taken | output | 1 | One-cycle pulse: entry outputs valid |
| vector | output | ADDR_W | Handler vector offset |
| saveAddr | output | ADDR_W | Saved return address |
| saveState | output | 32 | Saved machine-state word |
| msrOut | output | 32 | Machine-state word for the handler |
| faultStatus | output | 32 | Data fault status word |
| faultAddrReg | output | ADDR_W | Captured data fault address |

## Verification
The properties assume that `msrIn` and `nextPc` are stable between the edge that accepts a request and the cycle in which `taken` is observed, because they relate outputs to the previous cycle's inputs. They also assume that the 32-bit state word layout has enable at bit 15, interrupt-endian at bit 16 and little-endian at bit 0. The stimulus changes inputs only on falling edges and holds each request set for whole cycles. It drives only the six defined sync kinds when it expects a fault to be taken, and it uses kinds 6 and 7 only as non-requests. Idle cycles separate the scenarios, so the one-cycle blocking window is exercised only on purpose.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  localparam int MSR_W = 32;

  // machine-state bit positions the unit acts on
  localparam int B_LE  = 0;
  localparam int B_FE1 = 8;
  localparam int B_FE0 = 11;
  localparam int B_EE  = 15;
  localparam int B_ILE = 16;

  // control bits cleared on every entry (EE PR FP FE0 SE BE FE1 IR DR RI LE)
  localparam logic [MSR_W-1:0] ENTRY_CLEAR = 32'h0000_EF33;

  typedef enum logic [3:0] {
    CL_NONE, CL_RESET, CL_MCHECK, CL_DATA, CL_INSTR, CL_ALIGN,
    CL_PROGRAM, CL_FPU, CL_SYSCALL, CL_EXT, CL_DEC
  } excClass_e;

  typedef struct packed {
    logic      take;
    excClass_e cls;
    logic      useCurrent;
    logic      loadFault;
  } strobe_t;

  function automatic logic [15:0] vectorOf(excClass_e c);
    case (c)
      CL_RESET:   return 16'h0100;
      CL_MCHECK:  return 16'h0200;
      CL_DATA:    return 16'h0300;
      CL_INSTR:   return 16'h0400;
      CL_EXT:     return 16'h0500;
      CL_ALIGN:   return 16'h0600;
      CL_PROGRAM: return 16'h0700;
      CL_FPU:     return 16'h0800;
      CL_DEC:     return 16'h0900;
      CL_SYSCALL: return 16'h0C00;
      default:    return 16'h0000;
    endcase
  endfunction

endpackage

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rstReq,
  input  logic       mchkReq,
  input  logic       syncValid,
  input  logic [2:0] syncKind,
  input  logic [1:0] syncCause,
  input  logic       extReq,
  input  logic       decReq,
  input  logic       intEnable,
  input  logic [1:0] fpMode,
  output strobe_t    strobe,
  output logic       taken
);

  excClass_e syncCls;
  excClass_e winner;
  logic      syncLive;

  always_comb begin
    case (syncKind)
      3'd0:    syncCls = CL_DATA;
      3'd1:    syncCls = CL_INSTR;
      3'd2:    syncCls = CL_ALIGN;
      3'd3:    syncCls = CL_PROGRAM;
      3'd4:    syncCls = CL_FPU;
      3'd5:    syncCls = CL_SYSCALL;
      default: syncCls = CL_NONE;
    endcase
  end

  // a disabled floating-point program check is dropped outright
  assign syncLive = syncValid && (syncCls != CL_NONE) &&
                    !(syncCls == CL_PROGRAM && syncCause == 2'd0 && fpMode == 2'b00);

  always_comb begin
    if (rstReq)                      winner = CL_RESET;
    else if (mchkReq)                winner = CL_MCHECK;
    else if (syncLive)               winner = syncCls;
    else if (extReq && intEnable)    winner = CL_EXT;
    else if (decReq && intEnable)    winner = CL_DEC;
    else                             winner = CL_NONE;
  end

  always_comb begin
    strobe.take       = !taken && (winner != CL_NONE);
    strobe.cls        = winner;
    strobe.useCurrent = (winner == CL_ALIGN) || (winner == CL_PROGRAM) || (winner == CL_FPU);
    strobe.loadFault  = (winner == CL_DATA);
  end

  always_ff @(posedge clk) begin
    if (!rstN) taken <= 1'b0;
    else       taken <= strobe.take;
  end

endmodule

// File: rtl/exc_entry_dpath.sv
module exc_entry_dpath
  import exc_entry_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int INSN_BYTES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [1:0]        syncCause,
  input  logic              faultStore,
  input  logic [ADDR_W-1:0] faultAddr,
  input  logic [ADDR_W-1:0] nextPc,
  input  logic [MSR_W-1:0]  msrIn,
  output logic [ADDR_W-1:0] vector,
  output logic [ADDR_W-1:0] saveAddr,
  output logic [MSR_W-1:0]  saveState,
  output logic [MSR_W-1:0]  msrOut,
  output logic [MSR_W-1:0]  faultStatus,
  output logic [ADDR_W-1:0] faultAddrReg
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

  logic [MSR_W-1:0]  stateNext, msrNext, statusNext, instrCause, progCause;
  logic [ADDR_W-1:0] addrNext;

  always_comb begin
    case (syncCause)
      2'd0:    instrCause = 32'h4000_0000;
      2'd1:    instrCause = 32'h0800_0000;
      default: instrCause = 32'h1000_0000;
    endcase
    case (syncCause)
      2'd0:    progCause = 32'h0010_0000;
      2'd1:    progCause = 32'h0008_0000;
      2'd2:    progCause = 32'h0004_0000;
      default: progCause = 32'h0002_0000;
    endcase
  end

  always_comb begin
    stateNext = msrIn;
    case (strobe.cls)
      CL_DATA, CL_FPU: stateNext[31:16] = '0;
      CL_INSTR:        stateNext = {16'h0000, msrIn[15:0]} | instrCause;
      CL_PROGRAM:      stateNext = {16'h0000, msrIn[15:0]} | progCause | 32'h0001_0000;
      default:         stateNext = msrIn;
    endcase
    msrNext       = msrIn & ~ENTRY_CLEAR;
    msrNext[B_LE] = msrIn[B_ILE];
    statusNext    = ((syncCause == 2'd0) ? 32'h4000_0000 : 32'h0800_0000) |
                    (faultStore ? 32'h0200_0000 : 32'h0);
    addrNext      = strobe.useCurrent ? nextPc - STEP : nextPc;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vector       <= '0;
      saveAddr     <= '0;
      saveState    <= '0;
      msrOut       <= '0;
      faultStatus  <= '0;
      faultAddrReg <= '0;
    end else if (strobe.take) begin
      vector    <= {{(ADDR_W-16){1'b0}}, vectorOf(strobe.cls)};
      saveAddr  <= addrNext;
      saveState <= stateNext;
      msrOut    <= msrNext;
      if (strobe.loadFault) begin
        faultStatus  <= statusNext;
        faultAddrReg <= faultAddr;
      end
    end
  end

endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import exc_entry_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int INSN_BYTES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rstReq,
  input  logic              mchkReq,
  input  logic              syncValid,
  input  logic [2:0]        syncKind,
  input  logic [1:0]        syncCause,
  input  logic              faultStore,
  input  logic [ADDR_W-1:0] faultAddr,
  input  logic              extReq,
  input  logic              decReq,
  input  logic [ADDR_W-1:0] nextPc,
  input  logic [31:0]       msrIn,
  output logic              taken,
  output logic [ADDR_W-1:0] vector,
  output logic [ADDR_W-1:0] saveAddr,
  output logic [31:0]       saveState,
  output logic [31:0]       msrOut,
  output logic [31:0]       faultStatus,
  output logic [ADDR_W-1:0] faultAddrReg
);

  strobe_t strobe;

  exc_entry_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .rstReq    (rstReq),
    .mchkReq   (mchkReq),
    .syncValid (syncValid),
    .syncKind  (syncKind),
    .syncCause (syncCause),
    .extReq    (extReq),
    .decReq    (decReq),
    .intEnable (msrIn[B_EE]),
    .fpMode    ({msrIn[B_FE0], msrIn[B_FE1]}),
    .strobe    (strobe),
    .taken     (taken)
  );

  exc_entry_dpath #(.ADDR_W(ADDR_W), .INSN_BYTES(INSN_BYTES)) u_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .syncCause    (syncCause),
    .faultStore   (faultStore),
    .faultAddr    (faultAddr),
    .nextPc       (nextPc),
    .msrIn        (msrIn),
    .vector       (vector),
    .saveAddr     (saveAddr),
    .saveState    (saveState),
    .msrOut       (msrOut),
    .faultStatus  (faultStatus),
    .faultAddrReg (faultAddrReg)
  );

endmodule

// File: rtl/exc_entry_checker.sv
module exc_entry_checker #(
  parameter int ADDR_W     = 32,
  parameter int INSN_BYTES = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              taken,
  input logic [ADDR_W-1:0] vector,
  input logic [ADDR_W-1:0] nextPc,
  input logic [ADDR_W-1:0] saveAddr,
  input logic [31:0]       msrIn,
  input logic [31:0]       msrOut,
  input logic [31:0]       faultStatus
);

  p_pulse_once_r11: assert property (@(posedge clk) disable iff (!rstN)
    taken |=> !taken);

  p_vector_legal_r10: assert property (@(posedge clk) disable iff (!rstN)
    taken |-> (vector inside {'h100, 'h200, 'h300, 'h400, 'h500, 'h600,
                              'h700, 'h800, 'h900, 'hC00}));

  p_ctrl_cleared_r9: assert property (@(posedge clk) disable iff (!rstN)
    taken |-> ((msrOut & 32'h0000_EF32) == 32'h0) && (msrOut[0] == $past(msrIn[16])));

  p_enable_gate_r3: assert property (@(posedge clk) disable iff (!rstN)
    (taken && (vector == 'h500 || vector == 'h900)) |-> $past(msrIn[15]));

  p_status_kept_r4: assert property (@(posedge clk) disable iff (!rstN)
    (taken && vector != 'h300) |-> $stable(faultStatus));

  p_current_addr_r6: assert property (@(posedge clk) disable iff (!rstN)
    (taken && vector == 'h700) |-> saveAddr == $past(nextPc) - ADDR_W'(INSN_BYTES));

endmodule

bind exc_entry_unit exc_entry_checker #(.ADDR_W(ADDR_W), .INSN_BYTES(INSN_BYTES)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .taken       (taken),
  .vector      (vector),
  .nextPc      (nextPc),
  .saveAddr    (saveAddr),
  .msrIn       (msrIn),
  .msrOut      (msrOut),
  .faultStatus (faultStatus)
);

// File: tb/exc_entry_unit_test.sv
module exc_entry_unit_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rstReq = 0, mchkReq = 0, syncValid = 0, faultStore = 0, extReq = 0, decReq = 0;
  logic [2:0]  syncKind = 0;
  logic [1:0]  syncCause = 0;
  logic [31:0] faultAddr = 0, nextPc = 0, msrIn = 0;
  logic        taken;
  logic [31:0] vector, saveAddr, saveState, msrOut, faultStatus, faultAddrReg;

  int checks = 0;
  int errors = 0;
  bit cmpOn = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_entry_unit uut (
    .clk(clk), .rstN(rstN), .rstReq(rstReq), .mchkReq(mchkReq),
    .syncValid(syncValid), .syncKind(syncKind), .syncCause(syncCause),
    .faultStore(faultStore), .faultAddr(faultAddr), .extReq(extReq),
    .decReq(decReq), .nextPc(nextPc), .msrIn(msrIn), .taken(taken),
    .vector(vector), .saveAddr(saveAddr), .saveState(saveState),
    .msrOut(msrOut), .faultStatus(faultStatus), .faultAddrReg(faultAddrReg)
  );

  // behavioural reference model
  logic        mTaken = 0;
  logic [31:0] mVec = 0, mAddr = 0, mState = 0, mMsr = 0, mStat = 0, mFA = 0;

  always @(posedge clk) begin
    int v;
    logic [31:0] st, nm;
    if (!rstN) begin
      mTaken <= 0; mVec <= 0; mAddr <= 0; mState <= 0; mMsr <= 0; mStat <= 0; mFA <= 0;
    end else if (mTaken) begin
      mTaken <= 0;
    end else begin
      v = 0;
      if (rstReq) v = 'h100;
      else if (mchkReq) v = 'h200;
      else if (syncValid && syncKind < 6 &&
               !(syncKind == 3 && syncCause == 0 && !msrIn[11] && !msrIn[8])) begin
        int kv[6] = '{'h300, 'h400, 'h600, 'h700, 'h800, 'hC00};
        v = kv[syncKind];
      end
      else if (extReq && msrIn[15]) v = 'h500;
      else if (decReq && msrIn[15]) v = 'h900;
      if (v != 0) begin
        st = msrIn;
        if (v == 'h300 || v == 'h800) st = st & 32'h0000FFFF;
        if (v == 'h400) st = (st & 32'h0000FFFF) |
          (syncCause == 0 ? 32'h40000000 : syncCause == 1 ? 32'h08000000 : 32'h10000000);
        if (v == 'h700) st = (st & 32'h0000FFFF) | 32'h00010000 | (32'h00100000 >> syncCause);
        nm = msrIn;
        foreach (nm[b]) if (b inside {15, 14, 13, 11, 10, 9, 8, 5, 4, 1}) nm[b] = 1'b0;
        nm[0] = msrIn[16];
        mTaken <= 1;
        mVec   <= v;
        mAddr  <= (v == 'h600 || v == 'h700 || v == 'h800) ? nextPc - 4 : nextPc;
        mState <= st;
        mMsr   <= nm;
        if (v == 'h300) begin
          mStat <= (syncCause == 0 ? 32'h40000000 : 32'h08000000) | (faultStore ? 32'h02000000 : 0);
          mFA   <= faultAddr;
        end
      end
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (cmpOn) begin
    check("R11 taken", {31'b0, taken}, {31'b0, mTaken});
    check("R10 vector", vector, mVec);
    check("R6 saveAddr", saveAddr, mAddr);
    check("R5/R7 saveState", saveState, mState);
    check("R9 msrOut", msrOut, mMsr);
    check("R4 faultStatus", faultStatus, mStat);
    check("R4 faultAddrReg", faultAddrReg, mFA);
  end

  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic clearReq();
    rstReq = 0; mchkReq = 0; syncValid = 0; extReq = 0; decReq = 0; faultStore = 0;
  endtask

  task automatic fault(int kind, int cause, bit st);
    syncValid = 1; syncKind = kind[2:0]; syncCause = cause[1:0]; faultStore = st;
    cyc(); clearReq(); cyc();
  endtask

  initial begin
    int cnt = 0;
    while (!done) begin
      @(posedge clk);
      cnt++;
      if (cnt > WATCHDOG) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    cyc(3);
    // R1: reset state
    check("R1 taken", {31'b0, taken}, 0);
    check("R1 vector", vector, 0);
    check("R1 faultStatus", faultStatus, 0);
    rstN = 1;
    cyc();
    check("R1 saveState", saveState, 0);
    cmpOn = 1;

    msrIn = 32'hABCD_9F53; nextPc = 32'h0000_4000; faultAddr = 32'hDEAD_BEE0;
    fault(0, 0, 0);                                  // data, not found, load
    faultAddr = 32'h1234_5670; nextPc = 32'h0000_5004;
    fault(0, 1, 1);                                  // data, protect, store
    check("R4 status store protect", faultStatus, 32'h0A00_0000);
    for (int c = 0; c < 4; c++) fault(1, c, 0);      // instruction faults
    for (int c = 0; c < 4; c++) begin                // program checks
      nextPc = 32'h0000_8000 + 32'(c * 16);
      fault(3, c, 0);
    end
    check("R7 trap state", saveState, 32'h0003_9F53);
    fault(2, 0, 0); fault(4, 0, 0); fault(5, 0, 0);  // align, fpu, syscall
    check("R6 syscall next", saveAddr, nextPc);

    // R8: disabled FP check dropped, decrementer wins
    msrIn = 32'h0001_8000;
    syncValid = 1; syncKind = 3; syncCause = 0; decReq = 1;
    cyc();
    check("R8 dropped fp, dec wins", vector, 32'h900);
    clearReq(); cyc();
    syncValid = 1; syncKind = 3; syncCause = 0;
    cyc();
    check("R8 no take", {31'b0, taken}, 0);
    syncKind = 7; cyc();
    check("R8 kind 7 ignored", {31'b0, taken}, 0);
    clearReq(); cyc();

    // R3: gated while enable is 0, retried later
    msrIn = 32'h0000_0900; extReq = 1;
    cyc(3);
    check("R3 gated", {31'b0, taken}, 0);
    msrIn = 32'h0001_8900;
    cyc();
    check("R3 retried", vector, 32'h500);
    clearReq(); cyc();

    // R2: priority
    msrIn = 32'hABCD_9F53;
    rstReq = 1; mchkReq = 1; syncValid = 1; syncKind = 0; extReq = 1; decReq = 1;
    cyc();
    check("R2 reset first", vector, 32'h100);
    rstReq = 0; cyc(2);
    check("R2 mcheck next", vector, 32'h200);
    mchkReq = 0; cyc(2);
    check("R2 sync next", vector, 32'h300);
    syncValid = 0; cyc(2);
    check("R2 ext before dec", vector, 32'h500);
    extReq = 0; cyc(2);
    check("R2 dec last", vector, 32'h900);

    // R11: held request taken every second cycle
    cyc();
    check("R11 blocked cycle", {31'b0, taken}, 0);
    cyc();
    check("R11 retaken", {31'b0, taken}, 1);
    clearReq(); cyc(2);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule